// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This block is a memory-mapped watchdog for a processor subsystem. Software reaches it through a small 32-bit register port that has an address, a write strobe, write data and combinational read data. A configuration word, which holds the enable, the prescale selection, the early-warning selection and a 16-bit reload value, only takes effect through a guarded two-step sequence. First comes a write to the control offset carrying an opening key. The very next bus write must then carry a commit key together with the new configuration. Any other next write cancels the attempt and leaves the old configuration in place.

Once enabled, a prescaler divides the clock into ticks. Each tick decrements the live count. When the count falls to a selectable fraction of the full range, the block raises a one-cycle early-warning pulse. When the count runs out, it raises a one-cycle expiry pulse that system logic turns into a reset. Software services the watchdog by repeating the guarded sequence with the enable set. This reloads the count and restarts the prescaler. A status offset shows the enable state and the live count.

Top module: `pwd_watchdog`

## Requirements
- R1: After reset the control read is 0, the status read is 0, the configuration is disabled, and both `early_warn_o` and `expire_o` are low.
- R2: A write to offset 0x0 with key byte [23:16] = 0xBE arms the lock. If the very next write goes to offset 0x0 with [23:16] = 0xDC, its configuration is applied: bit 31 enable, [27:26] warning select, [25:24] prescale select, [15:0] reload.
- R3: While armed, any next write that is not a 0xDC write to offset 0x0 returns the lock to the locked state with the configuration unchanged. This covers a wrong key, another 0xBE, and any write to another offset. A 0xDC write while locked is ignored.
- R4: A read of offset 0x0 returns the configuration in its write positions. Bits [30:28] and the key field [23:16] read as zero.
- R5: A read of offset 0x8 returns the enable in bit 31 and the live count in [15:0]. All other bits read as zero. Any other offset reads 0.
- R6: Prescale select n gives one tick every 2^(DIV_BASE_LOG2 + n*DIV_STEP_LOG2) clocks. With the defaults this is 0x40, 0x400, 0x4000 or 0x40000 clocks. The first decrement comes one full period after the applying write.
- R7: `expire_o` is high for exactly one cycle, in the cycle after the tick that takes the count to 0. That is reload × period clocks after the applying write. A reload of 0 expires on the first tick. After expiry the count stays at 0 and no further pulse comes until the next applied configuration.
- R8: `early_warn_o` is high for one cycle after the tick that takes the count to 0xFFFF >> (w+1), where w is the warning select (w=3 gives 0x0FFF and w=0 gives 0x7FFF). A reload at or below that threshold never warns.
- R9: Every applied configuration loads the count from the reload field and restarts the prescaler. If the applying write lands on the edge of the expiring tick, the service wins and no expiry pulse occurs.
- R10: An applied configuration with bit 31 clear stops the watchdog. The count holds the loaded reload value and neither pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Byte offset of the register access |
| reg_we_i | input | 1 | Write strobe, one write per cycle when high |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| early_warn_o | output | 1 | One-cycle early-warning pulse |
| expire_o | output | 1 | One-cycle expiry (reset request) pulse |

## Verification
Servicing and expiry can coincide. The commit write that reloads the counter may land on the same edge as the tick that would take the count from 1 to 0. The bench starts a short count with a known period and counts edges from the applying write. It places the next opening-key write and commit write so that the commit falls exactly on the expiring edge. It then requires that no expiry pulse follows that edge and that the next pulse comes one full reload × period later. The lock's one-write window is provoked in a similar way: an arming write is followed by a write to the status offset, by a second opening key, or by a wrong key, and the control readback must show the old configuration each time.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DATA_W   = 32;
    localparam int CNT_W    = 16;
    localparam int KEY_LSB  = 16;
    localparam int DSEL_LSB = 24;
    localparam int WSEL_LSB = 26;
    localparam int EN_BIT   = 31;

    localparam logic [7:0] KEY_OPEN   = 8'hBE;
    localparam logic [7:0] KEY_COMMIT = 8'hDC;

    typedef struct packed {
        logic             run;
        logic [1:0]       warn_sel;
        logic [1:0]       div_sel;
        logic [CNT_W-1:0] reload;
    } cfg_t;

    typedef enum logic {
        LOCKED = 1'b0,
        ARMED  = 1'b1
    } lock_e;

    function automatic cfg_t unpack_cfg(input logic [DATA_W-1:0] w);
        cfg_t c;
        c.run      = w[EN_BIT];
        c.warn_sel = w[WSEL_LSB +: 2];
        c.div_sel  = w[DSEL_LSB +: 2];
        c.reload   = w[CNT_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg(input cfg_t c);
        logic [DATA_W-1:0] w;
        w                 = '0;
        w[EN_BIT]         = c.run;
        w[WSEL_LSB +: 2]  = c.warn_sel;
        w[DSEL_LSB +: 2]  = c.div_sel;
        w[CNT_W-1:0]      = c.reload;
        return w;
    endfunction

endpackage

// File: rtl/wdg_keylock.sv
module wdg_keylock
    import wdg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              wr_ctrl_i,
    input  logic [DATA_W-1:0] wdata_i,
    output cfg_t              cfg_o,
    output logic              apply_o,
    output cfg_t              new_cfg_o
);

    typedef struct packed {
        lock_e st;
        cfg_t  cfg;
    } lock_state_t;

    lock_state_t s_d, s_q;
    logic [7:0]  key;

    always_comb begin
        s_d       = s_q;
        apply_o   = 1'b0;
        key       = wdata_i[KEY_LSB +: 8];
        new_cfg_o = unpack_cfg(wdata_i);
        if (wr_i) begin
            if (s_q.st == ARMED) begin
                s_d.st = LOCKED;
                if (wr_ctrl_i && key == KEY_COMMIT) begin
                    apply_o = 1'b1;
                    s_d.cfg = new_cfg_o;
                end
            end else if (wr_ctrl_i && key == KEY_OPEN) begin
                s_d.st = ARMED;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cfg_o = s_q.cfg;

    // R3: the armed window lasts for one write only
    assert_one_write_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == ARMED && wr_i) |=> (s_q.st == LOCKED));

    // R3: a write seen while locked never alters the configuration
    assert_locked_holds_cfg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == LOCKED && wr_i) |=> $stable(s_q.cfg));

    // R2: a commit installs exactly the configuration it carried
    assert_commit_installs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        apply_o |=> (cfg_o == $past(new_cfg_o)));

endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
    parameter int BASE_LOG2 = 6,
    parameter int STEP_LOG2 = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);

    localparam int PW = BASE_LOG2 + 3 * STEP_LOG2;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t    s_d, s_q;
    logic [PW-1:0] lim;
    int            sh;

    always_comb begin
        s_d    = s_q;
        sh     = BASE_LOG2 + int'(sel_i) * STEP_LOG2;
        lim    = {PW{1'b1}} >> (PW - sh);
        tick_o = run_i && !restart_i && (s_q.cnt == lim);
        if (restart_i) begin
            s_d.cnt = '0;
        end else if (run_i) begin
            s_d.cnt = tick_o ? '0 : s_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R9: a restart always begins a fresh period
    assert_restart_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (s_q.cnt == '0));

    generate
        if (BASE_LOG2 >= 1) begin : g_spacing
            // R6: ticks are never back to back when the period is at least two
            assert_tick_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/wdg_count.sv
module wdg_count
    import wdg_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             apply_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [1:0]       warn_sel_i,
    output logic [CNT_W-1:0] count_o,
    output logic             warn_o,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             spent;
        logic             warn;
        logic             expire;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] dec;

    always_comb begin
        s_d        = s_q;
        s_d.warn   = 1'b0;
        s_d.expire = 1'b0;
        thr        = {CNT_W{1'b1}} >> (int'(warn_sel_i) + 1);
        dec        = s_q.cnt - CNT_W'(1);
        if (apply_i) begin
            s_d.cnt   = load_i;
            s_d.spent = 1'b0;
        end else if (run_i && tick_i && !s_q.spent) begin
            if (s_q.cnt <= CNT_W'(1)) begin
                s_d.cnt    = '0;
                s_d.spent  = 1'b1;
                s_d.expire = 1'b1;
            end else begin
                s_d.cnt  = dec;
                s_d.warn = (dec == thr);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign count_o  = s_q.cnt;
    assign warn_o   = s_q.warn;
    assign expire_o = s_q.expire;

    // R7: expiry lasts one cycle
    assert_expire_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> !expire_o);

    // R7: once spent, no second expiry without a new configuration
    assert_spent_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.spent && !apply_i) |=> !expire_o);

    // R8: the warning lasts one cycle
    assert_warn_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        warn_o |=> !warn_o);

    // R10: a stopped watchdog holds its count and stays silent
    assert_stopped_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !apply_i) |=> ($stable(count_o) && !expire_o && !warn_o));

    // R9: a service suppresses both pulses on its edge
    assert_service_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        apply_i |=> (!expire_o && !warn_o && count_o == $past(load_i)));

endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int DIV_BASE_LOG2 = 6,
    parameter int DIV_STEP_LOG2 = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              early_warn_o,
    output logic              expire_o
);

    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(8);

    cfg_t             cfg_q;
    cfg_t             new_cfg;
    logic             apply;
    logic             tick;
    logic             wr_ctrl;
    logic [CNT_W-1:0] count;

    assign wr_ctrl = reg_we_i && (reg_addr_i == CTRL_OFS);

    wdg_keylock i_keylock (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (reg_we_i),
        .wr_ctrl_i (wr_ctrl),
        .wdata_i   (reg_wdata_i),
        .cfg_o     (cfg_q),
        .apply_o   (apply),
        .new_cfg_o (new_cfg)
    );

    wdg_prescale #(
        .BASE_LOG2 (DIV_BASE_LOG2),
        .STEP_LOG2 (DIV_STEP_LOG2)
    ) i_prescale (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (cfg_q.run),
        .restart_i (apply),
        .sel_i     (cfg_q.div_sel),
        .tick_o    (tick)
    );

    wdg_count i_count (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (cfg_q.run),
        .tick_i     (tick),
        .apply_i    (apply),
        .load_i     (new_cfg.reload),
        .warn_sel_i (cfg_q.warn_sel),
        .count_o    (count),
        .warn_o     (early_warn_o),
        .expire_o   (expire_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == CTRL_OFS) begin
            reg_rdata_o = pack_cfg(cfg_q);
        end else if (reg_addr_i == STAT_OFS) begin
            reg_rdata_o[EN_BIT]    = cfg_q.run;
            reg_rdata_o[CNT_W-1:0] = count;
        end
    end

    // R8: warning and expiry thresholds never coincide
    assert_pulses_disjoint_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |-> !early_warn_o);

endmodule

// File: tb/test_pwd_watchdog.sv
module test_pwd_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [31:0]   data;
        logic [31:0]   ctrl_exp;
    } vec_t;

    localparam int NV = 16;
    // R2 R3 R4: each write is followed by a control readback
    localparam vec_t VECS [NV] = '{
        '{4'h0, 32'h00BE_0000, 32'h0000_0000},
        '{4'h0, 32'h03DC_0010, 32'h0300_0010},
        '{4'h0, 32'h01DC_0020, 32'h0300_0010},
        '{4'h0, 32'h00BE_0000, 32'h0300_0010},
        '{4'h8, 32'h00DC_0030, 32'h0300_0010},
        '{4'h0, 32'h00DC_0030, 32'h0300_0010},
        '{4'h0, 32'h00BE_0000, 32'h0300_0010},
        '{4'h0, 32'h00BE_0000, 32'h0300_0010},
        '{4'h0, 32'h0CDC_0040, 32'h0300_0010},
        '{4'h0, 32'h00BE_0000, 32'h0300_0010},
        '{4'h0, 32'h0CAA_0040, 32'h0300_0010},
        '{4'h0, 32'h0CDC_0040, 32'h0300_0010},
        '{4'h0, 32'h00BE_0000, 32'h0300_0010},
        '{4'h0, 32'h7FDC_FFFF, 32'h0F00_FFFF},
        '{4'h0, 32'h00BE_0000, 32'h0F00_FFFF},
        '{4'h0, 32'h08DC_1234, 32'h0800_1234}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          warn;
    logic          expire;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwd_watchdog #(
        .ADDR_W        (AW),
        .DIV_BASE_LOG2 (1),
        .DIV_STEP_LOG2 (1)
    ) i_pwd_watchdog (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .reg_addr_i   (addr),
        .reg_we_i     (we),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .early_warn_o (warn),
        .expire_o     (expire)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic service(input logic [31:0] d);
        wr(4'h0, 32'h00BE_0000);
        wr(4'h0, d);
    endtask

    // edges until the chosen pulse is seen; lim+1 when absent
    task automatic wait_pulse(input bit want_warn, input int lim,
                              output int n, output bit warn_seen);
        bit done;
        done      = 1'b0;
        n         = lim + 1;
        warn_seen = 1'b0;
        for (int i = 1; i <= lim && !done; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (warn) warn_seen = 1'b1;
            if (want_warn ? warn : expire) begin
                n    = i;
                done = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int          n;
        bit          ws;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v);  check("R1 ctrl", v, 32'h0);
        rd(4'h8, v);  check("R1 status", v, 32'h0);
        check("R1 warn", {31'b0, warn}, 32'h0);
        check("R1 expire", {31'b0, expire}, 32'h0);

        // R2 R3 R4 lock sequence table
        for (int k = 0; k < NV; k++) begin
            wr(VECS[k].addr, VECS[k].data);
            rd(4'h0, v);
            check($sformatf("R2/R3/R4 vector %0d", k), v, VECS[k].ctrl_exp);
        end

        // R5 R10: stopped, count holds the loaded reload
        rd(4'h8, v);  check("R5 status stopped", v, 32'h0000_1234);
        rd(4'hC, v);  check("R5 unused offset", v, 32'h0);
        wait_pulse(1'b0, 40, n, ws);
        check("R10 no expiry when stopped", n, 41);
        check("R10 no warning when stopped", {31'b0, ws}, 32'h0);
        rd(4'h8, v);  check("R10 count frozen", v, 32'h0000_1234);

        // R7 R6: reload 5, period 4
        service(32'h8DDC_0005);
        rd(4'h8, v);  check("R5 status loaded", v, 32'h8000_0005);
        wait_pulse(1'b0, 100, n, ws);
        check("R7 expiry cycle", n, 20);
        check("R8 no warning below threshold", {31'b0, ws}, 32'h0);
        rd(4'h8, v);  check("R7 count at zero", v, 32'h8000_0000);
        @(negedge clk);
        check("R7 one cycle pulse", {31'b0, expire}, 32'h0);
        wait_pulse(1'b0, 60, n, ws);
        check("R7 no repeat after expiry", n, 61);

        // R8 warning at 0x0FFF, period 2
        service(32'h8CDC_1003);
        wait_pulse(1'b1, 100, n, ws);
        check("R8 warning cycle sel3", n, 8);
        rd(4'h8, v);  check("R8 count at threshold", v, 32'h8000_0FFF);
        @(negedge clk);
        check("R8 one cycle warning", {31'b0, warn}, 32'h0);

        // R8 warning at 0x7FFF
        service(32'h80DC_8001);
        wait_pulse(1'b1, 100, n, ws);
        check("R8 warning cycle sel0", n, 4);

        // R6 slowest period 16
        service(32'h83DC_0002);
        wait_pulse(1'b0, 100, n, ws);
        check("R6 period sel3", n, 32);

        // R7 reload zero expires on first tick, period 2
        service(32'h80DC_0000);
        wait_pulse(1'b0, 100, n, ws);
        check("R7 reload zero", n, 2);

        // R9 service lands on the expiring edge
        service(32'h80DC_0005);
        repeat (8) @(negedge clk);
        service(32'h80DC_0005);
        check("R9 no expiry on service edge", {31'b0, expire}, 32'h0);
        wait_pulse(1'b0, 100, n, ws);
        check("R9 full period after service", n, 10);

        // R10 stop after running
        service(32'h00DC_0077);
        rd(4'h8, v);  check("R10 stopped status", v, 32'h0000_0077);
        wait_pulse(1'b0, 40, n, ws);
        check("R10 silent after stop", n, 41);
        rd(4'h8, v);  check("R10 count held", v, 32'h0000_0077);

        finish_run();
    end

endmodule